// File: doc/BRIEF.md
# Software Reset Control Port

This block is a one-byte register on the I/O port space, decoded at address 0xCF9, through which software asks for a system reset. Writing the register with the trigger bit set sends a request toward the system reset logic. Writing it with the trigger bit clear records only the reset-type choice. Reading the register returns the recorded value. What the system does after a request is handled elsewhere. This block only produces a one-cycle request pulse.

The block connects to a simple synchronous I/O strobe interface. Each access lasts one cycle and presents an address, a write or read strobe, and write data. Read data comes back one cycle later, qualified by a valid flag. A level output reports whether the recorded value is non-zero, so that save and restore logic can tell whether the register needs attention.

Top module: `sys_reset_ctl`

## Requirements
- R1: Only accesses whose address equals the port parameter (default 0xCF9) reach the register.
- R2: A write to the port with data bit 2 set drives `rst_req` high for exactly the one cycle that follows the write cycle. `rst_req` is low in every other cycle.
- R3: A write to the port with data bit 2 set leaves the recorded value unchanged.
- R4: A write to the port with data bit 2 clear records data bit 1 in bit 1. Every other recorded bit becomes zero.
- R5: A read of the port raises `io_rvalid` in the next cycle, with `io_rdata` equal to the value recorded before the read cycle.
- R6: A read of any other address leaves `io_rvalid` low, and `io_rdata` is held at zero while `io_rvalid` is low.
- R7: A write to any other address changes neither the recorded value nor `rst_req`.
- R8: While `rst_n` is low, the recorded value, `rst_req` and `io_rvalid` are all zero.
- R9: `reg_nonzero` is high exactly when the recorded value is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O access address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not valid |
| io_rvalid | output | 1 | Read data valid, one cycle after a read of the port |
| rst_req | output | 1 | One-cycle system reset request |
| reg_nonzero | output | 1 | High while the recorded value is non-zero |

## Verification
The assertions check the following on every cycle:
- A trigger write produces a request pulse and leaves the recorded value unchanged.
- A pulse never appears without a trigger write.
- A type write keeps only bit 1.
- Read data is valid only after a read of the port.
- The non-zero flag agrees with what a read returns.

Some behaviour can be shown only by the bench's scenarios, which compare against a behavioural model on every clock:
- Addresses next to the port are rejected.
- Back-to-back trigger writes each produce their own pulse.
- A read in the same cycle as a write returns the value recorded before that write.
- An asynchronous reset clears a recorded value.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9;
  parameter int TRIG_BIT = 2;
  parameter int TYPE_BIT = 1;

  typedef logic [DATA_W-1:0] rcr_byte_t;

  // access decoded against the port
  typedef struct packed {
    logic wr_hit;
    logic rd_hit;
    logic trig;
  } rcr_dec_t;

  function automatic logic port_match(input logic [ADDR_W-1:0] addr,
                                      input logic [ADDR_W-1:0] port);
    return addr == port;
  endfunction

  function automatic logic is_trigger(input rcr_byte_t d);
    return d[TRIG_BIT];
  endfunction

  // value kept by a non-trigger write
  function automatic rcr_byte_t keep_type(input rcr_byte_t d);
    rcr_byte_t m;
    m = '0;
    m[TYPE_BIT] = 1'b1;
    return d & m;
  endfunction

endpackage

// File: rtl/rcr_port_decode.sv
module rcr_port_decode
  import rcr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter logic [AW-1:0] PORT = PORT_ADDR
) (
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output rcr_dec_t      dec
);

  logic hit;

  always_comb begin
    hit        = port_match(io_addr, PORT);
    dec.wr_hit = io_wr & hit;
    dec.rd_hit = io_rd & hit;
    dec.trig   = dec.wr_hit & is_trigger(io_wdata);
  end

endmodule

// File: rtl/rcr_req_pulse.sv
module rcr_req_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rst_req
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= trig;
  end

  // R2
  trig_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> rst_req);

  // R2
  no_stray_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> !rst_req);

endmodule

// File: rtl/rcr_store.sv
module rcr_store
  import rcr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  rcr_dec_t      dec,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_rvalid,
  output logic          reg_nonzero
);

  logic [DW-1:0] stored;
  logic          type_wr;

  assign type_wr     = dec.wr_hit & ~dec.trig;
  assign reg_nonzero = |stored;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stored <= '0;
    else if (type_wr) stored <= keep_type(io_wdata);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= dec.rd_hit;
      io_rdata  <= dec.rd_hit ? stored : '0;
    end
  end

  // R3
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec.trig |=> $stable(stored));

  // R4
  type_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    type_wr |=> stored == ($past(io_wdata) & (1 << TYPE_BIT)));

  // R6
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec.rd_hit |=> !io_rvalid && io_rdata == '0);

  // R9
  flag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> (io_rdata != '0) == $past(reg_nonzero));

endmodule

// File: rtl/sys_reset_ctl.sv
module sys_reset_ctl
  import rcr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter logic [AW-1:0] PORT = PORT_ADDR
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [DW-1:0] io_wdata,
  output logic [DW-1:0] io_rdata,
  output logic          io_rvalid,
  output logic          rst_req,
  output logic          reg_nonzero
);

  rcr_dec_t dec;

  rcr_port_decode #(.AW(AW), .DW(DW), .PORT(PORT)) u_dec (
    .io_addr (io_addr),
    .io_wr   (io_wr),
    .io_rd   (io_rd),
    .io_wdata(io_wdata),
    .dec     (dec)
  );

  rcr_store #(.DW(DW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec        (dec),
    .io_wdata   (io_wdata),
    .io_rdata   (io_rdata),
    .io_rvalid  (io_rvalid),
    .reg_nonzero(reg_nonzero)
  );

  rcr_req_pulse u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (dec.trig),
    .rst_req(rst_req)
  );

  // R1
  off_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr != PORT) |=> !rst_req && !io_rvalid);

  // R7
  off_port_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr != PORT && !io_rd) |=> $stable(reg_nonzero));

endmodule

// File: tb/sys_reset_ctl_bench.sv
module sys_reset_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rvalid;
  logic        rst_req;
  logic        reg_nonzero;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  int m_store = 0;
  int m_req = 0;
  int m_rvalid = 0;
  int m_rdata = 0;

  always #5 clk = ~clk;

  sys_reset_ctl u_sys_reset_ctl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .rst_req(rst_req), .reg_nonzero(reg_nonzero)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_store = 0; m_req = 0; m_rvalid = 0; m_rdata = 0;
    end else begin
      bit hit;
      hit = (io_addr == 16'hCF9);
      m_req    = (io_wr && hit && io_wdata[2]) ? 1 : 0;
      m_rvalid = (io_rd && hit) ? 1 : 0;
      m_rdata  = (io_rd && hit) ? m_store : 0;
      if (io_wr && hit && !io_wdata[2]) m_store = io_wdata[1] ? 2 : 0;
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    if (!done) begin
      chk(rst_req == m_req[0], "R2 rst_req", rst_req, m_req);
      chk(io_rvalid == m_rvalid[0], "R5/R6 io_rvalid", io_rvalid, m_rvalid);
      chk(io_rdata == m_rdata[7:0], "R5/R6 io_rdata", io_rdata, m_rdata);
      chk(reg_nonzero == (m_store != 0), "R9 reg_nonzero", reg_nonzero, m_store != 0);
    end
  end

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_wdata = '0;
  endtask

  task automatic do_read(input logic [15:0] a, input bit exp_v,
                         input logic [7:0] exp_d, input string tag);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    #1;
    chk(io_rvalid == exp_v, tag, io_rvalid, exp_v);
    chk(io_rdata == exp_d, tag, io_rdata, exp_d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(rst_req == 0 && io_rvalid == 0 && reg_nonzero == 0, "R8 reset state",
        {rst_req, io_rvalid, reg_nonzero}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(16'hCF9, 1, 8'h00, "R8 read after reset");

    // R2 R3 trigger with all bits set
    do_write(16'hCF9, 8'hFF);
    #1 chk(rst_req == 1, "R2 pulse after trigger", rst_req, 1);
    @(negedge clk);
    #1 chk(rst_req == 0, "R2 pulse one cycle", rst_req, 0);
    do_read(16'hCF9, 1, 8'h00, "R3 trigger does not store");

    // R4 type write
    do_write(16'hCF9, 8'h02);
    do_read(16'hCF9, 1, 8'h02, "R4 type bit stored");
    do_write(16'hCF9, 8'hFB);
    do_read(16'hCF9, 1, 8'h02, "R4 other bits dropped");
    do_write(16'hCF9, 8'hF9);
    do_read(16'hCF9, 1, 8'h00, "R4 type bit clear");
    do_write(16'hCF9, 8'h02);

    // R3 trigger keeps stored 2
    do_write(16'hCF9, 8'h06);
    #1 chk(rst_req == 1, "R2 pulse with type", rst_req, 1);
    do_read(16'hCF9, 1, 8'h02, "R3 value kept across trigger");

    // R1 R7 neighbours ignored
    do_write(16'hCF8, 8'h00);
    do_write(16'hCFA, 8'h04);
    #1 chk(rst_req == 0, "R7 no pulse off port", rst_req, 0);
    do_write(16'h0CF9 ^ 16'h1000, 8'h04);
    #1 chk(rst_req == 0, "R1 high address bit differs", rst_req, 0);
    do_read(16'hCF9, 1, 8'h02, "R7 value kept after off-port writes");
    do_read(16'hCF8, 0, 8'h00, "R6 off-port read");
    do_read(16'hDF9, 0, 8'h00, "R1 off-port read");

    // back-to-back triggers
    io_addr = 16'hCF9; io_wdata = 8'h04; io_wr = 1'b1;
    @(negedge clk);
    #1 chk(rst_req == 1, "R2 first of pair", rst_req, 1);
    @(negedge clk);
    io_wr = 1'b0;
    #1 chk(rst_req == 1, "R2 second of pair", rst_req, 1);
    @(negedge clk);
    #1 chk(rst_req == 0, "R2 after pair", rst_req, 0);

    // R5 read with simultaneous write returns old value
    io_addr = 16'hCF9; io_wdata = 8'h00; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    #1 chk(io_rdata == 8'h02, "R5 read sees prior value", io_rdata, 2);
    chk(reg_nonzero == 0, "R9 flag cleared", reg_nonzero, 0);

    // R8 asynchronous reset clears stored value
    do_write(16'hCF9, 8'h02);
    #1 chk(reg_nonzero == 1, "R9 flag set", reg_nonzero, 1);
    #2 rst_n = 1'b0;
    #1 chk(reg_nonzero == 0, "R8 async clear", reg_nonzero, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(16'hCF9, 1, 8'h00, "R8 read after mid reset");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule